// File: doc/BRIEF.md
# Strided Page-Split Descriptor Builder

This block takes a rectangular transfer between system memory and a device address space and breaks it into DMA descriptors. The request gives the number of lines, the bytes per line, a start address and a stride on each side. The device stride is signed, so the device side can be walked bottom-up to flip an image vertically. Each line is cut wherever it would cross a system-memory page. As a result, a descriptor never spans two pages and the pages can sit anywhere in physical memory.

Before any walk, the request is screened. A bad request ends at once with a reason code and produces no descriptors. A good request is walked in one of two modes. Counting mode only reports how many descriptors the walk yields, so software can size descriptor storage. Emit mode produces the descriptors on a valid/ready stream. Each descriptor links back to the one emitted before it. The first one carries only the end-of-chain flag, and the last one emitted becomes the chain head. Hardware that follows the chain from the head therefore runs the chunks in reverse order of emission.

Descriptor slot addresses come from a base address input, with 16 bytes per slot.

Top module: `desc_chain_builder`

## Requirements
- R1: Each descriptor length is the smaller of the bytes left in the current page (PAGE_BYTES, default 4096) and the bytes left in the line. The next descriptor of the same line starts at memory and device addresses advanced by that length. No descriptor crosses a page boundary and none has length zero.
- R2: After the last chunk of a line, the next line begins at the previous line start plus the memory stride on the memory side. On the device side it begins at the previous line start plus the sign-extended device stride, which may be negative.
- R3: `desc_next_o` of the first emitted descriptor is 2 (the end-of-chain flag). For every later descriptor it is `desc_base_i + 16*(k-1)`, where k is that descriptor's zero-based emission index.
- R4: When a walk completes, `done_o` pulses for one cycle with `busy_o` low. At that point `desc_cnt_o` holds the total descriptor count and `chain_start_o` holds `desc_base_i + 16*(count-1)`.
- R5: With `count_only_i` high at start, the walk produces the same count as emit mode, and `desc_valid_o` stays low throughout. `desc_valid_o` is never high while `busy_o` is low.
- R6: A request with zero lines or zero line length is rejected with `err_o`=1. Otherwise, more than 2048 lines is rejected with `err_o`=2. A rejected request pulses `done_o` the cycle after start with `desc_cnt_o`=0 and emits nothing.
- R7: Failing none of the above, a memory stride above 8192 bytes, or a memory stride that exceeds the line length by one page or more, is rejected with `err_o`=3.
- R8: Failing none of the above, a memory stride below the line length, or a device stride whose magnitude is below the line length, is rejected with `err_o`=4.
- R9: Failing none of the above, a memory address or memory stride not a multiple of 16, or a device address or device stride not a multiple of 4, is rejected with `err_o`=5. An accepted request reports `err_o`=0.
- R10: While `desc_valid_o` is high and `desc_ready_i` is low, the descriptor stays valid and all its fields hold.
- R11: A `start_i` pulse while `busy_o` is high is ignored, and the walk in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept request when idle |
| count_only_i | input | 1 | 1: count descriptors only, 0: emit them |
| mem_addr_i | input | AW | System memory start address |
| dev_addr_i | input | AW | Device start address |
| line_len_i | input | LW | Bytes per line |
| line_cnt_i | input | NW | Number of lines |
| mem_stride_i | input | LW | Memory bytes between line starts |
| dev_stride_i | input | LW | Signed device bytes between line starts |
| desc_base_i | input | AW | Address of descriptor slot 0 |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion or rejection pulse |
| err_o | output | 3 | Rejection reason, 0 when accepted |
| desc_cnt_o | output | CW | Descriptor count of last request |
| chain_start_o | output | AW | Chain head address of last request |
| desc_valid_o | output | 1 | Descriptor on the stream is valid |
| desc_ready_i | input | 1 | Consumer takes the descriptor |
| desc_mem_o | output | AW | Descriptor memory address |
| desc_dev_o | output | AW | Descriptor device address |
| desc_len_o | output | LW | Descriptor byte count |
| desc_next_o | output | AW | Link to previously emitted descriptor or end flag |

## Verification
The bench covers lines that end exactly on a page edge, which must not produce a zero-length chunk. It also covers lines that start 16 bytes before a page and lines of a full 8192 bytes that split into three pieces. An off-by-one in the page-room comparison would show up in these cases as an extra or overlong descriptor. A negative device stride is used, because a design that zero-extends the stride would jump forward instead of back. Each rejection threshold is exercised on both sides of its boundary, including a stride excess of exactly one page against one 16 bytes less. Random backpressure and a start pulse issued mid-walk expose a stream that slips a descriptor, or a walk that restarts, since either would break the scoreboard's ordered comparison of addresses and back links.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  typedef enum logic [2:0] {
    DCB_OK          = 3'd0,
    DCB_ERR_EMPTY   = 3'd1,
    DCB_ERR_LINES   = 3'd2,
    DCB_ERR_MSTRIDE = 3'd3,
    DCB_ERR_SHORT   = 3'd4,
    DCB_ERR_ALIGN   = 3'd5
  } dcb_err_e;

  typedef enum logic {ST_IDLE, ST_WALK} dcb_state_e;

  localparam int unsigned EOC_FLAG = 2;
endpackage

// File: rtl/dcb_req_check.sv
module dcb_req_check
  import dcb_pkg::*;
#(
  parameter int AW          = 32,
  parameter int LW          = 16,
  parameter int NW          = 16,
  parameter int PAGE_BYTES  = 4096,
  parameter int MAX_LINES   = 2048,
  parameter int MAX_MSTRIDE = 8192,
  parameter int MEM_ALIGN   = 16,
  parameter int DEV_ALIGN   = 4
) (
  input  logic [AW-1:0] mem_addr_i,
  input  logic [AW-1:0] dev_addr_i,
  input  logic [LW-1:0] line_len_i,
  input  logic [NW-1:0] line_cnt_i,
  input  logic [LW-1:0] mem_stride_i,
  input  logic [LW-1:0] dev_stride_i,
  output dcb_err_e      err_o
);
  localparam int MA_SH = $clog2(MEM_ALIGN);
  localparam int DA_SH = $clog2(DEV_ALIGN);
  localparam logic [NW:0] MAX_L  = (NW+1)'(MAX_LINES);
  localparam logic [LW:0] MAX_MS = (LW+1)'(MAX_MSTRIDE);
  localparam logic [LW:0] PG     = (LW+1)'(PAGE_BYTES);

  logic          empty_b, lines_b, range_b, short_b, mis_m, mis_d;
  logic [LW:0]   excess;
  logic [LW-1:0] dev_mag;

  assign excess  = {1'b0, mem_stride_i} - {1'b0, line_len_i};
  assign dev_mag = dev_stride_i[LW-1] ? (~dev_stride_i + LW'(1)) : dev_stride_i;

  assign empty_b = (line_cnt_i == '0) || (line_len_i == '0);
  assign lines_b = {1'b0, line_cnt_i} > MAX_L;
  assign range_b = ({1'b0, mem_stride_i} > MAX_MS) ||
                   ((mem_stride_i >= line_len_i) && (excess >= PG));
  assign short_b = (mem_stride_i < line_len_i) || (dev_mag < line_len_i);

  generate
    if (MA_SH > 0) begin : g_mem_al
      assign mis_m = (|mem_addr_i[MA_SH-1:0]) | (|mem_stride_i[MA_SH-1:0]);
    end else begin : g_mem_any
      assign mis_m = 1'b0;
    end
    if (DA_SH > 0) begin : g_dev_al
      assign mis_d = (|dev_addr_i[DA_SH-1:0]) | (|dev_stride_i[DA_SH-1:0]);
    end else begin : g_dev_any
      assign mis_d = 1'b0;
    end
  endgenerate

  // first failing rule wins
  always_comb begin
    if (empty_b)             err_o = DCB_ERR_EMPTY;
    else if (lines_b)        err_o = DCB_ERR_LINES;
    else if (range_b)        err_o = DCB_ERR_MSTRIDE;
    else if (short_b)        err_o = DCB_ERR_SHORT;
    else if (mis_m || mis_d) err_o = DCB_ERR_ALIGN;
    else                     err_o = DCB_OK;
  end
endmodule

// File: rtl/dcb_chunk_calc.sv
module dcb_chunk_calc #(
  parameter int AW         = 32,
  parameter int LW         = 16,
  parameter int PAGE_BYTES = 4096
) (
  input  logic [AW-1:0] cur_mem_i,
  input  logic [LW-1:0] rem_i,
  output logic [LW-1:0] chunk_o,
  output logic          line_end_o
);
  localparam int PS   = $clog2(PAGE_BYTES);
  localparam int CMPW = (LW > PS + 1) ? LW : PS + 1;

  logic [CMPW-1:0] room, rem_w;

  assign room       = CMPW'(PAGE_BYTES) - CMPW'(cur_mem_i[PS-1:0]);
  assign rem_w      = CMPW'(rem_i);
  assign line_end_o = rem_w <= room;
  assign chunk_o    = line_end_o ? rem_i : LW'(room);
endmodule

// File: rtl/dcb_link_calc.sv
module dcb_link_calc
  import dcb_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int DESC_BYTES = 16
) (
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] idx_i,
  output logic [AW-1:0] self_o,
  output logic [AW-1:0] next_o
);
  localparam int DS = $clog2(DESC_BYTES);

  assign self_o = base_i + (AW'(idx_i) << DS);
  // backward chain: point at the slot written just before this one
  assign next_o = (idx_i == '0) ? AW'(EOC_FLAG) : (self_o - AW'(DESC_BYTES));
endmodule

// File: rtl/desc_chain_builder.sv
module desc_chain_builder
  import dcb_pkg::*;
#(
  parameter int AW          = 32,
  parameter int LW          = 16,
  parameter int NW          = 16,
  parameter int CW          = 16,
  parameter int PAGE_BYTES  = 4096,
  parameter int MAX_LINES   = 2048,
  parameter int MAX_MSTRIDE = 8192,
  parameter int MEM_ALIGN   = 16,
  parameter int DEV_ALIGN   = 4,
  parameter int DESC_BYTES  = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          count_only_i,
  input  logic [AW-1:0] mem_addr_i,
  input  logic [AW-1:0] dev_addr_i,
  input  logic [LW-1:0] line_len_i,
  input  logic [NW-1:0] line_cnt_i,
  input  logic [LW-1:0] mem_stride_i,
  input  logic [LW-1:0] dev_stride_i,
  input  logic [AW-1:0] desc_base_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [2:0]    err_o,
  output logic [CW-1:0] desc_cnt_o,
  output logic [AW-1:0] chain_start_o,
  output logic          desc_valid_o,
  input  logic          desc_ready_i,
  output logic [AW-1:0] desc_mem_o,
  output logic [AW-1:0] desc_dev_o,
  output logic [LW-1:0] desc_len_o,
  output logic [AW-1:0] desc_next_o
);
  localparam int SX = AW - LW;

  dcb_state_e    st_q;
  logic          cnt_mode_q, done_q;
  dcb_err_e      err_q, chk_err;
  logic [AW-1:0] base_q, line_mem_q, line_dev_q, cur_mem_q, cur_dev_q, chain_q;
  logic [LW-1:0] len_q, mstr_q, dstr_q, rem_q;
  logic [NW-1:0] lines_left_q;
  logic [CW-1:0] idx_q, cnt_q;

  logic [LW-1:0] chunk;
  logic          line_end, step, accept;
  logic [AW-1:0] self_addr, next_addr, mem_nl, dev_nl, dstr_ext;

  dcb_req_check #(
    .AW(AW), .LW(LW), .NW(NW), .PAGE_BYTES(PAGE_BYTES), .MAX_LINES(MAX_LINES),
    .MAX_MSTRIDE(MAX_MSTRIDE), .MEM_ALIGN(MEM_ALIGN), .DEV_ALIGN(DEV_ALIGN)
  ) i_req_check (
    .mem_addr_i  (mem_addr_i),
    .dev_addr_i  (dev_addr_i),
    .line_len_i  (line_len_i),
    .line_cnt_i  (line_cnt_i),
    .mem_stride_i(mem_stride_i),
    .dev_stride_i(dev_stride_i),
    .err_o       (chk_err)
  );

  dcb_chunk_calc #(.AW(AW), .LW(LW), .PAGE_BYTES(PAGE_BYTES)) i_chunk_calc (
    .cur_mem_i (cur_mem_q),
    .rem_i     (rem_q),
    .chunk_o   (chunk),
    .line_end_o(line_end)
  );

  dcb_link_calc #(.AW(AW), .CW(CW), .DESC_BYTES(DESC_BYTES)) i_link_calc (
    .base_i(base_q),
    .idx_i (idx_q),
    .self_o(self_addr),
    .next_o(next_addr)
  );

  assign accept   = start_i && (st_q == ST_IDLE);
  assign step     = (st_q == ST_WALK) && (cnt_mode_q || desc_ready_i);
  assign dstr_ext = {{SX{dstr_q[LW-1]}}, dstr_q};
  assign mem_nl   = line_mem_q + AW'(mstr_q);
  assign dev_nl   = line_dev_q + dstr_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      cnt_mode_q   <= 1'b0;
      done_q       <= 1'b0;
      err_q        <= DCB_OK;
      base_q       <= '0;
      line_mem_q   <= '0;
      line_dev_q   <= '0;
      cur_mem_q    <= '0;
      cur_dev_q    <= '0;
      chain_q      <= '0;
      len_q        <= '0;
      mstr_q       <= '0;
      dstr_q       <= '0;
      rem_q        <= '0;
      lines_left_q <= '0;
      idx_q        <= '0;
      cnt_q        <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        err_q <= chk_err;
        if (chk_err != DCB_OK) begin
          done_q  <= 1'b1;
          cnt_q   <= '0;
          chain_q <= '0;
        end else begin
          st_q         <= ST_WALK;
          cnt_mode_q   <= count_only_i;
          base_q       <= desc_base_i;
          line_mem_q   <= mem_addr_i;
          line_dev_q   <= dev_addr_i;
          cur_mem_q    <= mem_addr_i;
          cur_dev_q    <= dev_addr_i;
          len_q        <= line_len_i;
          mstr_q       <= mem_stride_i;
          dstr_q       <= dev_stride_i;
          rem_q        <= line_len_i;
          lines_left_q <= line_cnt_i;
          idx_q        <= '0;
        end
      end else if (step) begin
        idx_q <= idx_q + CW'(1);
        if (line_end) begin
          if (lines_left_q == NW'(1)) begin
            st_q    <= ST_IDLE;
            done_q  <= 1'b1;
            cnt_q   <= idx_q + CW'(1);
            chain_q <= self_addr;
          end else begin
            lines_left_q <= lines_left_q - NW'(1);
            line_mem_q   <= mem_nl;
            line_dev_q   <= dev_nl;
            cur_mem_q    <= mem_nl;
            cur_dev_q    <= dev_nl;
            rem_q        <= len_q;
          end
        end else begin
          cur_mem_q <= cur_mem_q + AW'(chunk);
          cur_dev_q <= cur_dev_q + AW'(chunk);
          rem_q     <= rem_q - chunk;
        end
      end
    end
  end

  assign busy_o        = st_q == ST_WALK;
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign desc_cnt_o    = cnt_q;
  assign chain_start_o = chain_q;
  assign desc_valid_o  = (st_q == ST_WALK) && !cnt_mode_q;
  assign desc_mem_o    = cur_mem_q;
  assign desc_dev_o    = cur_dev_q;
  assign desc_len_o    = chunk;
  assign desc_next_o   = next_addr;
endmodule

// File: rtl/desc_chain_builder_chk.sv
module desc_chain_builder_chk #(
  parameter int AW         = 32,
  parameter int LW         = 16,
  parameter int CW         = 16,
  parameter int PAGE_BYTES = 4096
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_i,
  input logic          done_i,
  input logic [2:0]    err_i,
  input logic [CW-1:0] cnt_i,
  input logic          desc_valid_i,
  input logic          desc_ready_i,
  input logic [AW-1:0] desc_mem_i,
  input logic [AW-1:0] desc_dev_i,
  input logic [LW-1:0] desc_len_i,
  input logic [AW-1:0] desc_next_i
);
  localparam int PS = $clog2(PAGE_BYTES);

  AST_VALID_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_i && !desc_ready_i |=> desc_valid_i); // R10

  AST_FIELDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_i && !desc_ready_i |=> $stable(desc_mem_i) && $stable(desc_dev_i) &&
                                      $stable(desc_len_i) && $stable(desc_next_i)); // R10

  AST_NO_PAGE_CROSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_i |-> (32'(desc_mem_i[PS-1:0]) + 32'(desc_len_i)) <= 32'(PAGE_BYTES)); // R1

  AST_LEN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_i |-> desc_len_i != '0); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !desc_valid_i); // R5

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i); // R4

  AST_REJECT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && (err_i != 3'd0) |-> cnt_i == '0); // R6
endmodule

bind desc_chain_builder desc_chain_builder_chk #(
  .AW(AW), .LW(LW), .CW(CW), .PAGE_BYTES(PAGE_BYTES)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_i      (busy_o),
  .done_i      (done_o),
  .err_i       (err_o),
  .cnt_i       (desc_cnt_o),
  .desc_valid_i(desc_valid_o),
  .desc_ready_i(desc_ready_i),
  .desc_mem_i  (desc_mem_o),
  .desc_dev_i  (desc_dev_o),
  .desc_len_i  (desc_len_o),
  .desc_next_i (desc_next_o)
);

// File: tb/test_desc_chain_builder.sv
`timescale 1ns/1ps
module test_desc_chain_builder;
  localparam int PAGE = 4096;

  typedef struct {
    logic [31:0] mem;
    logic [31:0] dev;
    logic [15:0] len;
    logic [31:0] nxt;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cmode = 1'b0;
  logic [31:0] mem_a = '0, dev_a = '0, base_a = '0;
  logic [15:0] len_v = '0, lines_v = '0, mstr = '0, dstr = '0;
  logic        ready = 1'b0;
  logic        busy, done, valid;
  logic [2:0]  err;
  logic [15:0] cnt, d_len;
  logic [31:0] chain, d_mem, d_dev, d_next;

  exp_t exp_q[$];
  int   n_chk = 0, n_fail = 0;
  int   rdy_mode = 0;
  logic [7:0] lfsr = 8'hA5;
  bit   ended = 0;

  always #10 clk = ~clk;

  desc_chain_builder i_desc_chain_builder (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .count_only_i(cmode),
    .mem_addr_i(mem_a), .dev_addr_i(dev_a), .line_len_i(len_v), .line_cnt_i(lines_v),
    .mem_stride_i(mstr), .dev_stride_i(dstr), .desc_base_i(base_a),
    .busy_o(busy), .done_o(done), .err_o(err), .desc_cnt_o(cnt), .chain_start_o(chain),
    .desc_valid_o(valid), .desc_ready_i(ready), .desc_mem_o(d_mem), .desc_dev_o(d_dev),
    .desc_len_o(d_len), .desc_next_o(d_next)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // ready changes mid-high-phase so the negedge monitor sees what the next edge uses
  initial begin
    forever begin
      @(posedge clk);
      #2;
      case (rdy_mode)
        0: ready = 1'b1;
        1: begin
          lfsr  = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          ready = lfsr[0];
        end
        default: ready = 1'b0;
      endcase
    end
  end

  // monitor: pop and compare on every handshake
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && valid && ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 unexpected descriptor", d_mem, 32'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(d_mem == e.mem, "R1 desc mem", d_mem, e.mem);
          chk(d_dev == e.dev, "R2 desc dev", d_dev, e.dev);
          chk(d_len == e.len, "R1 desc len", 32'(d_len), 32'(e.len));
          chk(d_next == e.nxt, "R3 desc next", d_next, e.nxt);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  task automatic run_req(input string tag, input logic cm, input logic [31:0] m, input logic [31:0] d,
                         input int len, input int lines, input int ms, input int ds,
                         input logic [31:0] base, input logic [2:0] exp_err,
                         input int rmode, input bit poke);
    int          exp_cnt;
    int          n;
    logic [31:0] mm, dd, exp_chain;
    exp_cnt = 0;
    if (exp_err == 3'd0) begin
      for (int l = 0; l < lines; l++) begin
        int rem;
        mm  = m + 32'(l * ms);
        dd  = d + 32'(l * ds);
        rem = len;
        while (rem > 0) begin
          int room, c;
          room = PAGE - int'(mm & 32'hFFF);
          c    = (room < rem) ? room : rem;
          if (!cm) begin
            exp_t e;
            e.mem = mm;
            e.dev = dd;
            e.len = 16'(c);
            e.nxt = (exp_cnt == 0) ? 32'd2 : base + 32'((exp_cnt - 1) * 16);
            exp_q.push_back(e);
          end
          exp_cnt++;
          mm  += 32'(c);
          dd  += 32'(c);
          rem -= c;
        end
      end
    end
    exp_chain = base + 32'((exp_cnt - 1) * 16);
    rdy_mode  = poke ? 2 : rmode;
    @(negedge clk);
    cmode = cm; mem_a = m; dev_a = d; len_v = 16'(len); lines_v = 16'(lines);
    mstr = 16'(ms); dstr = 16'(ds); base_a = base;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(busy, "R11 busy before poke", 32'(busy), 32'd1);
      lines_v = 16'd0; mem_a = 32'h3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      rdy_mode = 0;
    end
    n = 0;
    while (!done && n < 50000) begin
      @(negedge clk);
      n++;
    end
    chk(done, {tag, " done pulse"}, 32'(done), 32'd1);
    chk(!busy, "R4 idle at done", 32'(busy), 32'd0);
    chk(err == exp_err, {tag, " err code"}, 32'(err), 32'(exp_err));
    if (exp_err == 3'd0) begin
      chk(cnt == 16'(exp_cnt), cm ? "R5 count only total" : "R4 total count", 32'(cnt), 32'(exp_cnt));
      if (!cm) chk(chain == exp_chain, "R4 chain start", chain, exp_chain);
    end else begin
      chk(cnt == 16'd0, {tag, " rejected count"}, 32'(cnt), 32'd0);
    end
    #1;
    chk(exp_q.size() == 0, {tag, " stream drained"}, 32'(exp_q.size()), 32'd0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy, "R4 reset busy", 32'(busy), 32'd0);
    chk(!valid, "R5 reset valid", 32'(valid), 32'd0);
    chk(!done, "R4 reset done", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 single chunk, R3 end-of-chain flag only
    run_req("R3 single", 0, 32'h1000_0100, 32'h40, 64, 1, 64, 64, 32'h8000_0000, 3'd0, 0, 0);
    // R2 negative device stride, page splits on early lines
    run_req("R2 flip", 0, 32'h0000_2FC0, 32'h0001_0000, 160, 4, 4032, -512, 32'h0004_0000, 3'd0, 0, 0);
    // R1 three pieces per line under random backpressure (R10)
    run_req("R10 backpressure", 0, 32'h0000_0FF0, 32'h0020_0000, 8192, 2, 8192, 8192, 32'h0000_1000, 3'd0, 1, 0);
    // R1 line ending exactly at page end, and line offset by 16
    run_req("R1 exact page", 0, 32'h0000_3000, 32'h0, 4096, 1, 4096, 4096, 32'h100, 3'd0, 0, 0);
    run_req("R1 offset page", 0, 32'h0000_3010, 32'h0, 4096, 2, 4096, -4096, 32'h200, 3'd0, 1, 0);
    // R5 counting mode
    run_req("R5 count", 1, 32'h0000_0FF0, 32'h0020_0000, 8192, 2, 8192, 8192, 32'h0, 3'd0, 0, 0);
    run_req("R6 max lines ok", 1, 32'h0, 32'h0, 16, 2048, 16, 16, 32'h0, 3'd0, 0, 0);
    // R7 boundary just accepted
    run_req("R7 excess below page", 1, 32'h0, 32'h0, 64, 3, 4144, 64, 32'h0, 3'd0, 0, 0);
    // rejections
    run_req("R6 zero lines", 0, 32'h0, 32'h0, 64, 0, 64, 64, 32'h0, 3'd1, 0, 0);
    run_req("R6 zero length", 0, 32'h0, 32'h0, 0, 4, 64, 64, 32'h0, 3'd1, 0, 0);
    run_req("R6 too many lines", 0, 32'h0, 32'h0, 16, 2049, 16, 16, 32'h0, 3'd2, 0, 0);
    run_req("R7 stride too big", 0, 32'h0, 32'h0, 16, 2, 8208, 16, 32'h0, 3'd3, 0, 0);
    run_req("R7 excess one page", 0, 32'h0, 32'h0, 64, 2, 4160, 64, 32'h0, 3'd3, 0, 0);
    run_req("R8 mem stride short", 0, 32'h0, 32'h0, 64, 2, 32, 64, 32'h0, 3'd4, 0, 0);
    run_req("R8 dev stride short", 0, 32'h0, 32'h0, 64, 2, 64, 32, 32'h0, 3'd4, 0, 0);
    run_req("R8 neg dev stride short", 0, 32'h0, 32'h0, 64, 2, 64, -32, 32'h0, 3'd4, 0, 0);
    run_req("R9 mem addr", 0, 32'h8, 32'h0, 64, 2, 64, 64, 32'h0, 3'd5, 0, 0);
    run_req("R9 mem stride", 0, 32'h0, 32'h0, 64, 2, 72, 72, 32'h0, 3'd5, 0, 0);
    run_req("R9 dev addr", 0, 32'h0, 32'h2, 64, 2, 64, 64, 32'h0, 3'd5, 0, 0);
    run_req("R9 dev stride", 0, 32'h0, 32'h0, 64, 2, 64, 66, 32'h0, 3'd5, 0, 0);
    // R11 start while busy is ignored
    run_req("R11 poke", 0, 32'h0000_1FE0, 32'h500, 96, 3, 128, 128, 32'h0000_9000, 3'd0, 0, 1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule